// File: doc/BRIEF.md
# Interrupt Request Aggregator with Wait Release

This block gathers a small set of maskable interrupt sources and a single non-maskable interrupt for a simple processor core. Every maskable source has its own set and clear strobe. The block keeps a bitmask of the sources that are live and drives a combined pending line that follows that mask. A non-maskable trigger does not take effect on its own edge. It schedules the interrupt for a later point in the core's running cycle count, and the interrupt becomes due only once the count reaches that point.

On each instruction boundary the block tells the core which interrupt to take. The non-maskable one has first claim. A maskable one is taken only when the core's disable flag allows it. Any change to that flag that the retiring instruction has requested is applied before this decision, so the status word the core stacks already holds the new value.

When the core is stalled in a wait instruction, a live maskable request or a fresh set strobe releases it. This happens even while maskable interrupts are disabled. On release the block asks the core to step its program counter past the wait instruction and reports how many extra cycles to add to the cycle count. A due non-maskable interrupt releases the wait in the same way.

Top module: `intr_gather`

## Requirements
- R1: A set strobe on any source bit makes `irq_pend` high from the clock edge that samples it.
- R2: A clear strobe removes its bits from the source mask. `irq_pend` falls only when no source bit is left.
- R3: When set and clear strobe the same source in the same cycle, the source ends up set.
- R4: A non-maskable trigger sampled while `cyc_i` equals C schedules the interrupt for C + NMI_DELAY (6 by default). `take_nmi` is high at an instruction boundary once `cyc_i` is at or beyond that value, and never before it.
- R5: After `take_nmi` has been given at a boundary, no further `take_nmi` occurs until a new trigger arrives. The schedule register holds the all-ones "idle" value.
- R6: When a non-maskable interrupt is due at a boundary, `take_irq` stays low even when a maskable request could be taken.
- R7: `take_irq` is high only at a boundary, with `irq_pend` high, no due non-maskable interrupt, and the effective disable flag clear.
- R8: While `waiting_i` is high, `wake` and `pc_advance` rise in the same cycle as any of these: `irq_pend` high, a set strobe, or a due non-maskable interrupt. The disable flag has no effect on this.
- R9: `cyc_add` equals WAKE_ADD (14 by default) in any cycle where `wake` is high, and is zero in every other cycle.
- R10: The effective disable flag `iflag_eff` equals `iflag_new_i` when `iflag_upd_i` is high and `iflag_i` otherwise. This effective value decides R7 in the same cycle.
- R11: Synchronous reset empties the mask, drops `irq_pend`, and loads the schedule register with its idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set_i | input | NSRC | Per-source set strobes |
| src_clr_i | input | NSRC | Per-source clear strobes |
| nmi_trig_i | input | 1 | Non-maskable trigger strobe |
| cyc_i | input | CW | Running cycle count of the core |
| iflag_i | input | 1 | Current interrupt-disable flag |
| iflag_upd_i | input | 1 | Retiring instruction has a pending change to the flag |
| iflag_new_i | input | 1 | Value of that pending change |
| waiting_i | input | 1 | Core is stalled in a wait instruction |
| bound_i | input | 1 | Instruction boundary strobe |
| irq_pend | output | 1 | Combined maskable request line |
| take_nmi | output | 1 | Take the non-maskable interrupt now |
| take_irq | output | 1 | Take the maskable interrupt now |
| wake | output | 1 | Release the wait stall |
| pc_advance | output | 1 | Step the program counter past the wait instruction |
| cyc_add | output | CW | Cycles to add to the count on release |
| iflag_eff | output | 1 | Disable flag after the pending change |

## Verification
The mask and `irq_pend` are registered, so their effect shows from the edge that samples the strobes. The bench drives strobes just after an edge and reads `irq_pend` only after the following edge. The decisions `take_nmi`, `take_irq`, `wake`, `pc_advance`, `cyc_add` and `iflag_eff` are combinational from state and present inputs. The bench reads them a few time units after driving, in the same cycle, before the edge that would change the state. A non-maskable schedule becomes visible one edge after its trigger, and the bench steps `cyc_i` through the window around the scheduled point, checking each boundary.

// File: rtl/intr_gather_pkg.sv
package intr_gather_pkg;

    typedef struct packed {
        logic nmi;
        logic irq;
        logic wake;
    } decide_t;

    function automatic logic [15:0] sched_at(input logic [15:0] now, input logic [15:0] dly);
        return now + dly;
    endfunction

endpackage

// File: rtl/intr_src_mask.sv
module intr_src_mask #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic            pend_o
);
    logic [NSRC-1:0] live_q;
    logic            pend_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           live_q[g] <= 1'b0;
            else if (set_i[g]) live_q[g] <= 1'b1;
            else if (clr_i[g]) live_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                pend_q <= 1'b0;
        else if (|set_i)                        pend_q <= 1'b1;
        else if ((live_q & ~clr_i) == '0)       pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    p_set_pend_r1: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> pend_o);
    p_keep_pend_r2: assert property (@(posedge clk) disable iff (rst)
        (pend_o && ((live_q & ~clr_i) != '0)) |=> pend_o);
    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (set_i[0] && clr_i[0]) |=> live_q[0]);
endmodule

// File: rtl/intr_nmi_sched.sv
module intr_nmi_sched
    import intr_gather_pkg::*;
#(
    parameter int CW        = 16,
    parameter int NMI_DELAY = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig_i,
    input  logic [CW-1:0] cyc_i,
    input  logic          taken_i,
    output logic          due_o
);
    localparam logic [CW-1:0] IDLE = '1;
    localparam logic [CW-1:0] DLY  = CW'(NMI_DELAY);

    logic [CW-1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (rst)          tgt_q <= IDLE;
        else if (trig_i)  tgt_q <= cyc_i + DLY;
        else if (taken_i) tgt_q <= IDLE;
    end

    assign due_o = (tgt_q != IDLE) && (cyc_i >= tgt_q);

    p_idle_after_take_r5: assert property (@(posedge clk) disable iff (rst)
        (taken_i && !trig_i) |=> (tgt_q == IDLE));
    p_trig_sched_r4: assert property (@(posedge clk) disable iff (rst)
        trig_i |=> (tgt_q == $past(cyc_i) + DLY));
endmodule

// File: rtl/intr_decide.sv
module intr_decide
    import intr_gather_pkg::*;
(
    input  logic    bound_i,
    input  logic    pend_i,
    input  logic    nmi_due_i,
    input  logic    set_any_i,
    input  logic    waiting_i,
    input  logic    iflag_eff_i,
    output decide_t dec_o
);
    always_comb begin
        dec_o.nmi  = bound_i && nmi_due_i;
        dec_o.irq  = bound_i && !nmi_due_i && pend_i && !iflag_eff_i;
        dec_o.wake = waiting_i && (pend_i || set_any_i || nmi_due_i);
    end

    always_comb begin
        a_prio_r6: assert (!(dec_o.nmi && dec_o.irq));
        a_mask_r7: assert (!(dec_o.irq && iflag_eff_i));
        a_wake_r8: assert (!dec_o.wake || waiting_i);
    end
endmodule

// File: rtl/intr_gather.sv
module intr_gather
    import intr_gather_pkg::*;
#(
    parameter int NSRC      = 4,
    parameter int CW        = 16,
    parameter int NMI_DELAY = 6,
    parameter int WAKE_ADD  = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_set_i,
    input  logic [NSRC-1:0] src_clr_i,
    input  logic            nmi_trig_i,
    input  logic [CW-1:0]   cyc_i,
    input  logic            iflag_i,
    input  logic            iflag_upd_i,
    input  logic            iflag_new_i,
    input  logic            waiting_i,
    input  logic            bound_i,
    output logic            irq_pend,
    output logic            take_nmi,
    output logic            take_irq,
    output logic            wake,
    output logic            pc_advance,
    output logic [CW-1:0]   cyc_add,
    output logic            iflag_eff
);
    localparam logic [CW-1:0] ADD = CW'(WAKE_ADD);

    logic    nmi_due;
    decide_t dec;

    assign iflag_eff = iflag_upd_i ? iflag_new_i : iflag_i;

    intr_src_mask #(.NSRC(NSRC)) u_mask (
        .clk(clk), .rst(rst), .set_i(src_set_i), .clr_i(src_clr_i), .pend_o(irq_pend)
    );

    intr_nmi_sched #(.CW(CW), .NMI_DELAY(NMI_DELAY)) u_nmi (
        .clk(clk), .rst(rst), .trig_i(nmi_trig_i), .cyc_i(cyc_i),
        .taken_i(dec.nmi), .due_o(nmi_due)
    );

    intr_decide u_dec (
        .bound_i(bound_i), .pend_i(irq_pend), .nmi_due_i(nmi_due),
        .set_any_i(|src_set_i), .waiting_i(waiting_i),
        .iflag_eff_i(iflag_eff), .dec_o(dec)
    );

    assign take_nmi   = dec.nmi;
    assign take_irq   = dec.irq;
    assign wake       = dec.wake;
    assign pc_advance = dec.wake;
    assign cyc_add    = dec.wake ? ADD : '0;

    p_add_only_on_wake_r9: assert property (@(posedge clk) disable iff (rst)
        (cyc_add != '0) |-> wake);
    p_reset_empty_r11: assert property (@(posedge clk)
        rst |=> !irq_pend);
endmodule

// File: tb/intr_gather_bench.sv
module intr_gather_bench;
    localparam int CLK_P = 10;
    localparam int NSRC  = 4;
    localparam int CW    = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic [NSRC-1:0] sset = '0, sclr = '0;
    logic nmi_trig = 0, iflag = 0, iupd = 0, inew = 0, waiting = 0, bound = 0;
    logic [CW-1:0] cyc = '0;
    logic irq_pend, take_nmi, take_irq, wake, pc_adv, iflag_eff;
    logic [CW-1:0] cyc_add;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    intr_gather #(.NSRC(NSRC), .CW(CW)) u_intr_gather (
        .clk(clk), .rst(rst), .src_set_i(sset), .src_clr_i(sclr), .nmi_trig_i(nmi_trig),
        .cyc_i(cyc), .iflag_i(iflag), .iflag_upd_i(iupd), .iflag_new_i(inew),
        .waiting_i(waiting), .bound_i(bound), .irq_pend(irq_pend), .take_nmi(take_nmi),
        .take_irq(take_irq), .wake(wake), .pc_advance(pc_adv), .cyc_add(cyc_add),
        .iflag_eff(iflag_eff)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        sset = '0; sclr = '0; nmi_trig = 0; bound = 0; waiting = 0; iupd = 0; iflag = 0;
    endtask

    initial begin
        #(CLK_P*60000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        edge1(); edge1(); edge1();
        rst = 0;
        bound = 1; cyc = 16'hFFFF; #2;
        chk(irq_pend == 0, "R11", irq_pend, 0);
        chk(take_nmi == 0, "R11", take_nmi, 0);
        edge1(); idle(); cyc = 0;

        // R1 each bit
        for (int b = 0; b < NSRC; b++) begin
            sclr = '1; edge1(); sclr = '0;
            sset = NSRC'(1 << b); edge1(); sset = '0;
            chk(irq_pend == 1, "R1", irq_pend, 1);
        end

        // R2 / R3 sweep
        for (int a = 0; a < 16; a++) begin
            for (int c = 0; c < 16; c++) begin
                sclr = '1; edge1();
                sclr = '0; sset = NSRC'(a); edge1();
                sset = '0; sclr = NSRC'(c); edge1();
                chk(irq_pend == ((a & ~c & 15) != 0), "R2", irq_pend, int'((a & ~c & 15) != 0));
                sset = NSRC'(c); sclr = NSRC'(c); edge1();
                sset = '0; sclr = NSRC'(~c & 15); edge1();
                sclr = '0;
                chk(irq_pend == (c != 0), "R3", irq_pend, int'(c != 0));
            end
        end
        sclr = '1; edge1(); sclr = '0;

        // R4 / R5
        foreach (cyc[i]) ;
        for (int k = 0; k < 3; k++) begin
            int c0;
            int taken;
            c0 = (k == 0) ? 0 : (k == 1) ? 37 : 500;
            taken = 0;
            cyc = CW'(c0); nmi_trig = 1; edge1(); nmi_trig = 0;
            for (int d = 0; d <= 9; d++) begin
                cyc = CW'(c0 + d); bound = 1; #2;
                if (d < 6) chk(take_nmi == 0, "R4", take_nmi, 0);
                else if (taken == 0) chk(take_nmi == 1, "R4", take_nmi, 1);
                else chk(take_nmi == 0, "R5", take_nmi, 0);
                if (take_nmi) taken = 1;
                edge1();
            end
            bound = 0;
        end

        // R6 priority
        sset = 4'b0010; cyc = 100; nmi_trig = 1; edge1(); sset = '0; nmi_trig = 0;
        cyc = 106; bound = 1; #2;
        chk(take_nmi == 1 && take_irq == 0, "R6", take_irq, 0);
        edge1();
        #2; chk(take_irq == 1, "R7", take_irq, 1);
        iflag = 1; #2; chk(take_irq == 0, "R7", take_irq, 0);
        bound = 0; #2; iflag = 0; chk(take_irq == 0, "R7", take_irq, 0);

        // R10
        bound = 1; iflag = 1; iupd = 1; inew = 0; #2;
        chk(iflag_eff == 0 && take_irq == 1, "R10", take_irq, 1);
        iflag = 0; inew = 1; #2;
        chk(iflag_eff == 1 && take_irq == 0, "R10", take_irq, 0);
        iupd = 0; bound = 0; edge1();

        // R8 / R9
        sclr = '1; edge1(); sclr = '0; waiting = 1; #2;
        chk(wake == 0 && pc_adv == 0, "R8", wake, 0);
        chk(cyc_add == 0, "R9", cyc_add, 0);
        sset = 4'b1000; iflag = 1; #2;
        chk(wake == 1 && pc_adv == 1, "R8", wake, 1);
        chk(cyc_add == 14, "R9", cyc_add, 14);
        edge1(); sset = '0; #2;
        chk(wake == 1, "R8", wake, 1);
        bound = 1; #2;
        chk(take_irq == 0, "R8", take_irq, 0);
        waiting = 0; #2;
        chk(wake == 0 && cyc_add == 0, "R9", cyc_add, 0);
        bound = 0; sclr = '1; edge1(); sclr = '0;
        cyc = 200; nmi_trig = 1; edge1(); nmi_trig = 0;
        cyc = 206; waiting = 1; #2;
        chk(wake == 1, "R8", wake, 1);
        idle(); edge1();

        // R11 reset mid-run
        sset = 4'b0101; cyc = 300; nmi_trig = 1; edge1(); sset = '0; nmi_trig = 0;
        rst = 1; edge1(); rst = 0; cyc = 400; bound = 1; #2;
        chk(irq_pend == 0, "R11", irq_pend, 0);
        chk(take_nmi == 0, "R11", take_nmi, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule